// File: doc/BRIEF.md
# Register-Programmed Clock Divider

This block turns a 32-bit control word into a clock division ratio. The control word holds a divider field, a two-bit encoding selector and a zero-bypass bit. The decoder maps the raw field to an actual divisor in one of four ways: field plus one, the raw value, a power of two, or a search through a parameter list of value/divisor pairs that ends at the first pair whose divisor is zero. A field value that has no legal meaning is rejected. The previous divisor then stays in force and a sticky error flag is raised.

The divided clock is produced in the clocked domain as a one-cycle enable pulse, `div_tick`, on the last input cycle of each output period. A registered phase level, `div_phase`, is high for the first half of each period. A downstream clock gate can turn these into a real clock. A divisor of one keeps the enable high on every cycle, which is the bypass case. A newly written ratio is held as pending and is loaded only when the current period ends, so no shortened period can appear. By default the register uses write-masked access: the upper half of each write selects which bits of the lower half may change.

Top module: `clkdiv_regfield`

## Requirements
- R1: A synchronous active-high reset clears the control register to 0, sets the divisor to 1 and clears the error flag. After reset, `div_tick` and `div_phase` are both high on every cycle.
- R2: In masked-write mode, bit i (i < 16) of the stored control word takes bit i of `wr_data` only if bit 16+i of the same write is 1. Otherwise it keeps its value. The upper 16 bits of `ctrl_rd` always read 0.
- R3: The divider field is bits [7:4], the encoding selector is bits [9:8] and the zero-bypass bit is bit 10. With encoding 0, the divisor is the field value plus one.
- R4: With encoding 1, a nonzero field is the divisor itself. A zero field with the bypass bit set gives divisor 1.
- R5: With encoding 1, a zero field with the bypass bit clear is rejected. The error flag goes high at the write's clock edge and the previous divisor stays in force.
- R6: With encoding 2, the divisor is 2 raised to the field value.
- R7: With encoding 3, the field is looked up in the pair list (1→2, 3→4, 6→7, then a terminator at value 9, then 5→3). The search stops at the terminator, so values 9 and 5 and any unlisted value are rejected in the same way as in R5.
- R8: Once raised, the error flag stays high through later valid writes until reset.
- R9: A new divisor appears on `cur_div` only on the cycle after a `div_tick`. The period that is running when the write occurs completes at its old length.
- R10: For a divisor d, `div_tick` is high once every d cycles, on the last cycle of the period. `div_phase` is high for the first ceil(d/2) cycles of each period and low for the rest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data; the upper half is the per-bit write enable in masked mode |
| ctrl_rd | output | 32 | Stored control word |
| cur_div | output | 16 | Divisor currently in force |
| div_tick | output | 1 | Enable pulse on the last cycle of each output period |
| div_phase | output | 1 | Divided clock level, high in the first half of the period |
| dec_err | output | 1 | Sticky flag for rejected field values |

## Verification
Each encoding is swept over its field values. The bench reads back the divisor and measures one full period of both the enable pulse and the phase level. These measurements separate off-by-one decoding, wrong duty split on odd ratios and wrong power scaling. For the table encoding, the sweep also covers values placed after the terminator and values that are not listed, which separates a search that stops at the terminator from one that runs through the whole list. Masked writes with partial, empty and disjoint enable patterns show whether the enable half is honoured. A write issued at the start of an 8-cycle period shows whether the change is deferred until that period ends.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  localparam int unsigned REG_W  = 32;
  localparam int unsigned HALF_W = 16;

  typedef enum logic [1:0] {
    ENC_PLUS1 = 2'd0,
    ENC_RAW   = 2'd1,
    ENC_POW2  = 2'd2,
    ENC_TABLE = 2'd3
  } enc_e;

  // Lower-half merge where the upper half of the write selects changing bits.
  function automatic logic [REG_W-1:0] merge_masked(
    input logic [REG_W-1:0] old_word,
    input logic [REG_W-1:0] wr_word
  );
    logic [HALF_W-1:0] sel;
    logic [HALF_W-1:0] lo;
    sel = wr_word[REG_W-1:HALF_W];
    lo  = (old_word[HALF_W-1:0] & ~sel) | (wr_word[HALF_W-1:0] & sel);
    return {{(REG_W-HALF_W){1'b0}}, lo};
  endfunction

  // Position pos of a period of length d lies in the high phase.
  function automatic logic in_high_phase(
    input logic [31:0] pos,
    input logic [31:0] d
  );
    return pos < ((d + 32'd1) >> 1);
  endfunction

endpackage

// File: rtl/cdv_ctrl_reg.sv
module cdv_ctrl_reg
  import clkdiv_pkg::*;
#(
  parameter bit MASK_WR = 1'b1,
  parameter int FLD_LSB = 4,
  parameter int FLD_W   = 4,
  parameter int ENC_LSB = 8,
  parameter int ZB_BIT  = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] ctrl_q,
  output logic [FLD_W-1:0] fld_nx,
  output enc_e             enc_nx,
  output logic             zb_nx
);

  logic [REG_W-1:0] ctrl_nx;

  generate
    if (MASK_WR) begin : g_masked
      always_comb ctrl_nx = wr_en ? merge_masked(ctrl_q, wr_data) : ctrl_q;
    end else begin : g_plain
      always_comb ctrl_nx = wr_en ? wr_data : ctrl_q;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else     ctrl_q <= ctrl_nx;
  end

  assign fld_nx = ctrl_nx[FLD_LSB +: FLD_W];
  assign enc_nx = enc_e'(ctrl_nx[ENC_LSB +: 2]);
  assign zb_nx  = ctrl_nx[ZB_BIT];

endmodule

// File: rtl/cdv_decode.sv
module cdv_decode
  import clkdiv_pkg::*;
#(
  parameter int FLD_W  = 4,
  parameter int DIVW   = 16,
  parameter int TBL_N  = 5,
  parameter int TBL_DW = 16,
  parameter logic [TBL_N*FLD_W-1:0]  TBL_VAL = '0,
  parameter logic [TBL_N*TBL_DW-1:0] TBL_DIV = '0
) (
  input  logic [FLD_W-1:0] fld,
  input  enc_e             enc,
  input  logic             zb,
  output logic             ok,
  output logic [DIVW-1:0]  div
);

  logic [FLD_W-1:0]  ent_val [TBL_N];
  logic [TBL_DW-1:0] ent_div [TBL_N];

  generate
    for (genvar i = 0; i < TBL_N; i++) begin : g_ent
      assign ent_val[i] = TBL_VAL[i*FLD_W +: FLD_W];
      assign ent_div[i] = TBL_DIV[i*TBL_DW +: TBL_DW];
    end
  endgenerate

  logic              tbl_hit;
  logic [TBL_DW-1:0] tbl_div;

  // The search stops at the first entry whose divisor is zero.
  always_comb begin
    logic alive;
    alive   = 1'b1;
    tbl_hit = 1'b0;
    tbl_div = '0;
    for (int i = 0; i < TBL_N; i++) begin
      if (alive) begin
        if (ent_div[i] == '0) begin
          alive = 1'b0;
        end else if (!tbl_hit && ent_val[i] == fld) begin
          tbl_hit = 1'b1;
          tbl_div = ent_div[i];
        end
      end
    end
  end

  always_comb begin
    ok  = 1'b1;
    div = DIVW'(1);
    case (enc)
      ENC_PLUS1: div = DIVW'(fld) + DIVW'(1);
      ENC_RAW: begin
        if (fld != '0) div = DIVW'(fld);
        else if (zb)   div = DIVW'(1);
        else           ok  = 1'b0;
      end
      ENC_POW2: div = DIVW'(1) << fld;
      ENC_TABLE: begin
        ok  = tbl_hit;
        div = tbl_hit ? DIVW'(tbl_div) : DIVW'(1);
      end
    endcase
  end

endmodule

// File: rtl/cdv_period.sv
module cdv_period
  import clkdiv_pkg::*;
#(
  parameter int DIVW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic            reject,
  input  logic [DIVW-1:0] new_div,
  output logic [DIVW-1:0] pend_div,
  output logic [DIVW-1:0] cur_div,
  output logic            tick,
  output logic            phase,
  output logic            err
);

  logic [DIVW-1:0] cnt_q, cnt_nx, act_q, act_nx, pend_q;
  logic            phase_q, err_q;

  assign tick = (cnt_q == act_q - DIVW'(1));

  always_comb begin
    cnt_nx = tick ? '0 : cnt_q + DIVW'(1);
    act_nx = tick ? pend_q : act_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      act_q   <= DIVW'(1);
      pend_q  <= DIVW'(1);
      phase_q <= 1'b1;
      err_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_nx;
      act_q   <= act_nx;
      phase_q <= in_high_phase(32'(cnt_nx), 32'(act_nx));
      if (load)   pend_q <= new_div;
      if (reject) err_q  <= 1'b1;
    end
  end

  assign pend_div = pend_q;
  assign cur_div  = act_q;
  assign phase    = phase_q;
  assign err      = err_q;

endmodule

// File: rtl/clkdiv_regfield.sv
module clkdiv_regfield
  import clkdiv_pkg::*;
#(
  parameter bit MASK_WR = 1'b1,
  parameter int FLD_LSB = 4,
  parameter int FLD_W   = 4,
  parameter int ENC_LSB = 8,
  parameter int ZB_BIT  = 10,
  parameter int TBL_N   = 5,
  parameter int TBL_DW  = 16,
  parameter logic [TBL_N*FLD_W-1:0]  TBL_VAL = 20'h5_9_6_3_1,
  parameter logic [TBL_N*TBL_DW-1:0] TBL_DIV = 80'h0003_0000_0007_0004_0002,
  parameter int DIVW = ((1 << FLD_W) > TBL_DW) ? (1 << FLD_W) : TBL_DW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [31:0]     wr_data,
  output logic [31:0]     ctrl_rd,
  output logic [DIVW-1:0] cur_div,
  output logic            div_tick,
  output logic            div_phase,
  output logic            dec_err
);

  logic [FLD_W-1:0] fld_nx;
  enc_e             enc_nx;
  logic             zb_nx;
  logic             dec_ok;
  logic [DIVW-1:0]  dec_div;
  logic [DIVW-1:0]  pend_div;
  logic             wr_accept;
  logic             wr_reject;

  cdv_ctrl_reg #(
    .MASK_WR(MASK_WR), .FLD_LSB(FLD_LSB), .FLD_W(FLD_W),
    .ENC_LSB(ENC_LSB), .ZB_BIT(ZB_BIT)
  ) u_reg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .ctrl_q(ctrl_rd), .fld_nx(fld_nx), .enc_nx(enc_nx), .zb_nx(zb_nx)
  );

  cdv_decode #(
    .FLD_W(FLD_W), .DIVW(DIVW), .TBL_N(TBL_N), .TBL_DW(TBL_DW),
    .TBL_VAL(TBL_VAL), .TBL_DIV(TBL_DIV)
  ) u_dec (
    .fld(fld_nx), .enc(enc_nx), .zb(zb_nx), .ok(dec_ok), .div(dec_div)
  );

  assign wr_accept = wr_en &  dec_ok;
  assign wr_reject = wr_en & ~dec_ok;

  cdv_period #(.DIVW(DIVW)) u_per (
    .clk(clk), .rst(rst), .load(wr_accept), .reject(wr_reject),
    .new_div(dec_div), .pend_div(pend_div), .cur_div(cur_div),
    .tick(div_tick), .phase(div_phase), .err(dec_err)
  );

endmodule

// File: rtl/cdv_checker.sv
module cdv_checker #(
  parameter int DIVW    = 16,
  parameter bit MASK_WR = 1'b1
) (
  input logic            clk,
  input logic            rst,
  input logic            wr_en,
  input logic [15:0]     wr_mask,
  input logic [31:0]     ctrl_rd,
  input logic [DIVW-1:0] cur_div,
  input logic [DIVW-1:0] pend_div,
  input logic            div_tick,
  input logic            div_phase,
  input logic            dec_err,
  input logic            wr_reject
);

  AST_RESET_LOAD: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (cur_div == DIVW'(1)) && !dec_err && (ctrl_rd == 32'h0)); // R1

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    dec_err |=> dec_err); // R8

  AST_REJECT_KEEP: assert property (@(posedge clk) disable iff (rst)
    wr_reject |=> $stable(pend_div) && dec_err); // R5

  AST_CHANGE_AT_END: assert property (@(posedge clk) disable iff (rst)
    !div_tick |=> $stable(cur_div)); // R9

  AST_PERIOD_OPENS_HIGH: assert property (@(posedge clk) disable iff (rst)
    div_tick |=> div_phase); // R10

  AST_PERIOD_CLOSES_LOW: assert property (@(posedge clk) disable iff (rst)
    div_tick && (cur_div > DIVW'(1)) |-> !div_phase); // R10

  AST_DIV_NONZERO: assert property (@(posedge clk) disable iff (rst)
    cur_div != '0); // R4

  generate
    if (MASK_WR) begin : g_mask_chk
      AST_EMPTY_MASK: assert property (@(posedge clk) disable iff (rst)
        wr_en && (wr_mask == 16'h0) |=> $stable(ctrl_rd)); // R2

      AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        ctrl_rd[31:16] == 16'h0); // R2
    end
  endgenerate

endmodule

bind clkdiv_regfield cdv_checker #(.DIVW(DIVW), .MASK_WR(MASK_WR)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_mask(wr_data[31:16]),
  .ctrl_rd(ctrl_rd), .cur_div(cur_div), .pend_div(pend_div),
  .div_tick(div_tick), .div_phase(div_phase), .dec_err(dec_err),
  .wr_reject(wr_reject)
);

// File: tb/sim_clkdiv_regfield.sv
`timescale 1ns/1ps
module sim_clkdiv_regfield;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] ctrl_rd;
  logic [15:0] cur_div;
  logic        div_tick, div_phase, dec_err;

  int total = 0;
  int bad = 0;
  int exp_cur = 1;
  bit done = 1'b0;

  always #5 clk = ~clk;

  clkdiv_regfield u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .ctrl_rd(ctrl_rd), .cur_div(cur_div), .div_tick(div_tick),
    .div_phase(div_phase), .dec_err(dec_err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // Divisor expected from the requirements; -1 marks a rejected value.
  function automatic int model(int enc, int f, int zb);
    case (enc)
      0: return f + 1;
      1: return (f != 0) ? f : (zb != 0 ? 1 : -1);
      2: return 1 << f;
      default: begin
        if (f == 1) return 2;
        if (f == 3) return 4;
        if (f == 6) return 7;
        return -1;
      end
    endcase
  endfunction

  function automatic logic [15:0] mk(int enc, int f, int zb);
    return 16'((zb << 10) | (enc << 8) | (f << 4));
  endfunction

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    wr_data = '0;
  endtask

  task automatic wait_tick();
    int n = 0;
    while (!div_tick && n < 70000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 70000) chk(1'b0, "R10", "tick timeout", n, 0);
  endtask

  task automatic settle();
    wait_tick();
    @(negedge clk);
  endtask

  task automatic measure(input int d, input string req);
    int errs = 0;
    wait_tick();
    for (int k = 0; k < d; k++) begin
      @(negedge clk);
      if (div_phase !== (k < (d + 1) / 2)) errs++;
      if (div_tick !== (k == d - 1)) errs++;
    end
    chk(errs == 0, req, "period shape mismatches", errs, 0);
  endtask

  task automatic apply(input int enc, input int f, input int zb, input string req);
    int e;
    e = model(enc, f, zb);
    wr({16'hFFFF, mk(enc, f, zb)});
    if (e < 0) chk(dec_err === 1'b1, req, "rejected value raises error", dec_err, 1);
    settle();
    if (e > 0) exp_cur = e;
    chk(int'(cur_div) == exp_cur, req, "divisor readback", cur_div, exp_cur);
    measure(exp_cur, req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(cur_div == 16'd1, "R1", "divisor after reset", cur_div, 1);
    chk(dec_err == 1'b0, "R1", "error after reset", dec_err, 0);
    chk(ctrl_rd == 32'h0, "R1", "control after reset", ctrl_rd, 0);
    chk(div_tick && div_phase, "R1", "bypass tick and phase", {div_tick, div_phase}, 3);

    // R2: masked writes
    wr({16'h00F0, 16'hFFFF});
    chk(ctrl_rd == 32'h0000_00F0, "R2", "partial mask set", ctrl_rd, 32'hF0);
    wr({16'h0010, 16'h0000});
    chk(ctrl_rd == 32'h0000_00E0, "R2", "single bit clear", ctrl_rd, 32'hE0);
    wr({16'h0000, 16'hFFFF});
    chk(ctrl_rd == 32'h0000_00E0, "R2", "empty mask ignored", ctrl_rd, 32'hE0);
    wr({16'hF000, 16'hA5A5});
    chk(ctrl_rd == 32'h0000_A0E0, "R2", "disjoint mask", ctrl_rd, 32'hA0E0);
    settle();
    exp_cur = 15;

    for (int f = 0; f < 16; f++) apply(0, f, 0, "R3");
    for (int f = 1; f < 16; f++) apply(1, f, 0, "R4");
    apply(1, 0, 1, "R4");
    for (int f = 0; f < 10; f++) apply(2, f, 0, "R6");

    // R5: rejected zero keeps the earlier divisor
    apply(0, 4, 0, "R5");
    apply(1, 0, 0, "R5");
    chk(cur_div == 16'd5, "R5", "divisor kept", cur_div, 5);

    for (int f = 0; f < 16; f++) apply(3, f, 0, "R7");
    chk(dec_err == 1'b1, "R8", "error stays after valid writes", dec_err, 1);

    // R9: change deferred to end of period
    apply(0, 7, 0, "R9");
    wait_tick();
    wr({16'hFFFF, mk(0, 2, 0)});
    chk(cur_div == 16'd8, "R9", "old divisor mid-period", cur_div, 8);
    n = 0;
    while (!div_tick && n < 100) begin
      @(negedge clk);
      n++;
    end
    chk(n == 6, "R9", "cycles until old period ends", n, 6);
    @(negedge clk);
    chk(cur_div == 16'd3, "R9", "new divisor after period end", cur_div, 3);
    exp_cur = 3;
    measure(3, "R10");

    // R1 and R8: reset clears the sticky error
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(dec_err == 1'b0, "R8", "error cleared by reset", dec_err, 0);
    chk(cur_div == 16'd1, "R1", "divisor after second reset", cur_div, 1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule